// File: doc/BRIEF.md
# Flicker-Register Upset Detector Array

The block is a bank of identical self-checking units. Its purpose is to turn a bit upset in the configuration memory of a programmable device into a logic malfunction that can be timed to the nearest clock. Each unit holds two wide registers. Each register is loaded through its own selector. A selector is a row of 4-input lookup cells. A single flicker signal drives one input of every cell, and the other three inputs are tied low. Each cell therefore reads one of two stored bits: one preset to 0 and one preset to 1. While the block is enabled, the flicker signal toggles on every clock. Both registers therefore swing between all-zero and all-one together, and a comparator checks them against each other every cycle.

An upset is modelled by an injection input that inverts one stored bit in the first selector of a unit. The corrupted value reaches that unit's register on the next load that reads the affected cell. One clock later the disagreement sets a sticky error flag. That flag is the trigger for a time-of-flight capture. The block also records the lowest-numbered unit that failed first, and a bitmap of every unit that has failed since the last clear.

Top module: `flicker_upset_array`

## Requirements
- R1: While reset is high and after it is released, `err_flag` is 0, `err_unit` is 0 and `fail_map` is 0.
- R2: The flicker value is 0 after reset and inverts on each enabled clock. Both registers of every unit reset to all-zero and load all-flicker-value on each enabled clock. With no upset injected, the error flag never rises.
- R3: Bit `u*WIDTH+b` of `upset` inverts the stored cell of bit b in the first selector of unit u. `upset_cell`=1 picks the cell preset to 1, and `upset_cell`=0 picks the cell preset to 0. The corruption reaches the register only on a load made while the flicker value equals `upset_cell`.
- R4: `err_flag` rises at the clock edge that directly follows the edge that wrote the corrupted value, and not before it.
- R5: `err_flag` stays high until `err_clear` is sampled high. A clear sets `err_flag`, `err_unit` and `fail_map` to 0 and takes priority over any capture in the same cycle.
- R6: `err_unit` holds the lowest index among the units that disagree in the cycle the flag is first set. Later failures do not change it until a clear.
- R7: Bit u of `fail_map` is set for every unit u that has disagreed in an enabled cycle since the last clear.
- R8: While `enable` is low, the flicker value and all registers hold, and no new error is captured.
- R9: A single upset in any bit of any unit, in either cell, is detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Advances flicker and register loads, and allows error capture |
| err_clear | input | 1 | Clears the sticky error state |
| upset_cell | input | 1 | Selects which stored cell the injection inverts (1 = the cell preset to 1) |
| upset | input | N_UNITS*WIDTH | Per-unit, per-bit upset injection into the first selector |
| err_flag | output | 1 | Sticky error and timing trigger |
| err_unit | output | IDX_W | Lowest failing unit at the first error |
| fail_map | output | N_UNITS | Units that have failed since the last clear |

## Verification
The hardest situation to reach from the ports is one where a corrupted cell is present but unseen: the injection sits on a cell that the current flicker phase does not read. The stimulus keeps its own model of the flicker phase by counting enabled edges since reset. For every unit, bit and cell, it injects in both the matching and the opposite phase. It then checks that the flag stays low until exactly one edge after the corrupted load. Further cases inject in two units in the same cycle and in sequence, to exercise lowest-index capture and bitmap accumulation, and inject while the block is disabled.

// File: rtl/upset_pkg.sv
package upset_pkg;
  // Lookup contents per cell: entry 1 holds 1, entry 0 holds 0.
  localparam logic [15:0] CELL_INIT = 16'h0002;

  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/flk_lut_row.sv
module flk_lut_row import upset_pkg::*; #(
  parameter int WIDTH = 32
) (
  input  logic             flick,
  input  logic             cell_sel,
  input  logic [WIDTH-1:0] upset,
  output logic [WIDTH-1:0] q
);
  logic [3:0] addr;
  assign addr = {3'b000, flick};

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    logic [15:0] mask;
    assign mask = CELL_INIT ^ ({15'b0, upset[i]} << cell_sel);
    assign q[i] = mask[addr];
  end
endmodule

// File: rtl/flk_cmp_unit.sv
module flk_cmp_unit #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             flick,
  input  logic             cell_sel,
  input  logic [WIDTH-1:0] upset,
  output logic             mism
);
  logic [WIDTH-1:0] sel_a, sel_b, reg_a, reg_b;

  flk_lut_row #(.WIDTH(WIDTH)) u_row_a (
    .flick(flick), .cell_sel(cell_sel), .upset(upset), .q(sel_a)
  );
  flk_lut_row #(.WIDTH(WIDTH)) u_row_b (
    .flick(flick), .cell_sel(cell_sel), .upset('0), .q(sel_b)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_a <= '0;
      reg_b <= '0;
    end else if (enable) begin
      reg_a <= sel_a;
      reg_b <= sel_b;
    end
  end

  assign mism = |(reg_a ^ reg_b);
endmodule

// File: rtl/flk_err_capture.sv
module flk_err_capture #(
  parameter int N_UNITS = 8,
  parameter int IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enable,
  input  logic               err_clear,
  input  logic [N_UNITS-1:0] mism,
  output logic               err_flag,
  output logic [IDX_W-1:0]   err_unit,
  output logic [N_UNITS-1:0] fail_map
);
  logic [IDX_W-1:0] lowest;

  always_comb begin
    lowest = '0;
    for (int i = N_UNITS - 1; i >= 0; i--) begin
      if (mism[i]) lowest = IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || err_clear) begin
      err_flag <= 1'b0;
      err_unit <= '0;
      fail_map <= '0;
    end else if (enable) begin
      fail_map <= fail_map | mism;
      if (!err_flag && (|mism)) begin
        err_flag <= 1'b1;
        err_unit <= lowest;
      end
    end
  end
endmodule

// File: rtl/flicker_upset_array.sv
module flicker_upset_array import upset_pkg::*; #(
  parameter int N_UNITS = 8,
  parameter int WIDTH   = 32,
  localparam int IDX_W  = idx_bits(N_UNITS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       enable,
  input  logic                       err_clear,
  input  logic                       upset_cell,
  input  logic [N_UNITS*WIDTH-1:0]   upset,
  output logic                       err_flag,
  output logic [IDX_W-1:0]           err_unit,
  output logic [N_UNITS-1:0]         fail_map
);
  logic               flick;
  logic [N_UNITS-1:0] mism;

  always_ff @(posedge clk) begin
    if (rst)         flick <= 1'b0;
    else if (enable) flick <= ~flick;
  end

  for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
    flk_cmp_unit #(.WIDTH(WIDTH)) u_unit (
      .clk      (clk),
      .rst      (rst),
      .enable   (enable),
      .flick    (flick),
      .cell_sel (upset_cell),
      .upset    (upset[u*WIDTH +: WIDTH]),
      .mism     (mism[u])
    );
  end

  flk_err_capture #(.N_UNITS(N_UNITS), .IDX_W(IDX_W)) u_cap (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .err_clear (err_clear),
    .mism      (mism),
    .err_flag  (err_flag),
    .err_unit  (err_unit),
    .fail_map  (fail_map)
  );
endmodule

// File: rtl/flicker_upset_chk.sv
module flicker_upset_chk import upset_pkg::*; #(
  parameter int N_UNITS = 8,
  localparam int IDX_W  = idx_bits(N_UNITS)
) (
  input logic               clk,
  input logic               rst,
  input logic               enable,
  input logic               err_clear,
  input logic               err_flag,
  input logic [IDX_W-1:0]   err_unit,
  input logic [N_UNITS-1:0] fail_map
);
  logic [N_UNITS-1:0] below;
  always_comb begin
    below = '0;
    for (int i = 0; i < N_UNITS; i++) begin
      if (IDX_W'(i) < err_unit) below[i] = 1'b1;
    end
  end

  // R5
  sticky_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (err_flag && !err_clear) |=> err_flag);

  // R5
  clear_wipes_chk: assert property (@(posedge clk) disable iff (rst)
    err_clear |=> (!err_flag && fail_map == '0 && err_unit == '0));

  // R6
  first_lowest_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err_flag) |-> ((fail_map & below) == '0 && fail_map[err_unit]));

  // R6
  unit_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (err_flag && !err_clear) |=> $stable(err_unit));

  // R8
  disabled_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!enable && !err_clear) |=> ($stable(fail_map) && $stable(err_flag)));

  // R7
  map_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (fail_map != '0) |-> err_flag);
endmodule

bind flicker_upset_array flicker_upset_chk #(.N_UNITS(N_UNITS)) u_chk (
  .clk(clk), .rst(rst), .enable(enable), .err_clear(err_clear),
  .err_flag(err_flag), .err_unit(err_unit), .fail_map(fail_map)
);

// File: tb/test_flicker_upset_array.sv
`timescale 1ns/1ps
module test_flicker_upset_array;
  localparam int N = 4;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst, enable, err_clear, upset_cell;
  logic [N*W-1:0] upset;
  logic         err_flag;
  logic [1:0]   err_unit;
  logic [N-1:0] fail_map;

  int checks = 0;
  int errors = 0;
  bit fm = 1'b0;  // model of flicker phase

  always #2 clk = ~clk;

  flicker_upset_array #(.N_UNITS(N), .WIDTH(W)) i_flicker_upset_array (
    .clk(clk), .rst(rst), .enable(enable), .err_clear(err_clear),
    .upset_cell(upset_cell), .upset(upset),
    .err_flag(err_flag), .err_unit(err_unit), .fail_map(fail_map)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    if (enable && !rst) fm = ~fm;
    @(negedge clk);
  endtask

  task automatic clear_all();
    err_clear = 1'b1;
    step();
    err_clear = 1'b0;
  endtask

  // single upset in unit u, bit b, cell c
  task automatic inject_one(input int u, input int b, input bit c);
    upset = '0;
    upset[u*W+b] = 1'b1;
    upset_cell = c;
    if (fm != c) begin
      step();  // clean load
      check("R3 unseen phase", int'(err_flag), 0);
    end
    step();    // corrupted load
    upset = '0;
    check("R4 not before", int'(err_flag), 0);
    step();
    check("R4 R9 flag", int'(err_flag), 1);
    check("R6 unit", int'(err_unit), u);
    check("R7 map", int'(fail_map), 1 << u);
    step();
    step();
    check("R5 sticky", int'(err_flag), 1);
    clear_all();
    check("R5 cleared flag", int'(err_flag), 0);
    check("R5 cleared map", int'(fail_map), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; enable = 1'b0; err_clear = 1'b0; upset_cell = 1'b0; upset = '0;
    @(negedge clk);
    step();
    step();
    check("R1 flag", int'(err_flag), 0);
    check("R1 unit", int'(err_unit), 0);
    check("R1 map", int'(fail_map), 0);
    rst = 1'b0;
    fm = 1'b0;
    enable = 1'b1;

    // R2: clean running, no error
    for (int k = 0; k < 20; k++) step();
    check("R2 idle flag", int'(err_flag), 0);
    check("R2 idle map", int'(fail_map), 0);

    // R9 sweep: every unit, bit, cell, both phases
    for (int u = 0; u < N; u++)
      for (int b = 0; b < W; b++)
        for (int c = 0; c < 2; c++) begin
          inject_one(u, b, bit'(c));
          step();  // shift phase for variety
        end

    // R6: two units fail together, lowest wins
    upset = '0; upset[1*W+2] = 1'b1; upset[3*W+5] = 1'b1; upset_cell = fm;
    step();
    upset = '0;
    step();
    check("R6 simultaneous unit", int'(err_unit), 1);
    check("R7 simultaneous map", int'(fail_map), 4'b1010);
    clear_all();

    // R6 R7: sequential failures keep first unit, accumulate map
    upset = '0; upset[2*W] = 1'b1; upset_cell = fm;
    step();
    upset = '0;
    step();
    check("R6 first seq unit", int'(err_unit), 2);
    upset[0*W+7] = 1'b1; upset_cell = fm;
    step();
    upset = '0;
    step();
    check("R6 held unit", int'(err_unit), 2);
    check("R7 accumulated map", int'(fail_map), 4'b0101);
    clear_all();
    step();
    step();

    // R8: disabled, injection has no effect
    enable = 1'b0;
    upset = '0; upset[3*W+1] = 1'b1;
    upset_cell = 1'b0; step(); step();
    upset_cell = 1'b1; step(); step();
    check("R8 disabled flag", int'(err_flag), 0);
    check("R8 disabled map", int'(fail_map), 0);
    upset = '0;
    enable = 1'b1;
    step(); step(); step();
    check("R8 resumed clean", int'(err_flag), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule